// File: doc/BRIEF.md
# Prioritised Interrupt Controller

This block sorts 32 level-sensitive interrupt lines and one non-maskable line into a single request for a processor core. Software sets the enable, pending and two-bit priority state of each line through word-wide registers. Enable and pending bits each have a separate set address and a separate clear address. A write of one changes a bit and a write of zero leaves it alone, so software never needs a read-modify-write sequence.

The arbiter looks at the lines that are pending and enabled, and that the global mask does not block. It picks the most urgent of them, presents its number, and asserts a request only when that priority is strictly more urgent than the level now in service. The core accepts the request with a take strobe. It ends the handler with a return strobe. A small stack of active levels lets nested handlers unwind to the level that was in service before. The non-maskable line ranks above every programmable level and has a fixed number one past the last line.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write to offset 0x100 sets the enable bit of every line whose data bit is one. A write to 0x180 clears them. Zero data bits leave bits unchanged. A read of either offset returns the enable mask, with bit n for line n.
- R2: Offsets 0x200 and 0x280 set and clear pending bits in the same write-one way. A read of either offset returns the pending mask.
- R3: The priority of line 4r+k sits in byte k of the word at offset 0x400+4r, for r from 0 to 7. Only bits [7:6] of each byte are kept, and the other bits read as zero.
- R4: A high line that is not in service makes its pending bit one on the next clock. A clear-pending write does not hold that bit clear while the line stays high.
- R5: The request carries the number of the pending, enabled line with the numerically lowest priority value. Among lines of equal value, the lowest line number wins. With nothing eligible, req_valid is low.
- R6: A pending line that is disabled makes no request but keeps its pending bit.
- R7: While mask_all is high, no line 0 to 31 is requested. The non-maskable line still is.
- R8: The non-maskable line is latched while it is high. It cannot be disabled, and it is requested as number 32 even during a handler running at priority 0x00.
- R9: A request is raised only when the winner is strictly more urgent than the active level. A winner of equal or lower urgency waits and stays pending.
- R10: A take clears the winner's pending bit and makes the winner's level active. A return restores the level that was active before that take.
- R11: A line that is high during its own handler does not pend again until the return. If it is still high after the return, it pends again.
- R12: A take in the same cycle as a return, or a take with no request raised, is ignored. The line stays pending and only the return takes effect.
- R13: A take in the same cycle as a set-pending write to the same line leaves that pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| mask_all | input | 1 | Blocks lines 0 to 31 while high |
| req_valid | output | 1 | An interrupt is ready to be taken |
| req_id | output | 6 | Number of the requested interrupt, 32 for the non-maskable line |
| req_take | input | 1 | Core accepts the current request |
| req_ret | input | 1 | Core finishes the current handler |

## Verification
The take strobe can meet a return strobe in one cycle, and it can also meet a set-pending write to the very line being taken. The bench creates each case by driving both strobes on the same falling edge. It then reads back the pending mask and the request. A take that meets a return must leave the line pending and requested, with the stack unwound. A take that meets a set-pending write must leave the bit set, and must raise it again as a request once the handler returns.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register file
  localparam int unsigned OFS_EN_SET    = 'h100;
  localparam int unsigned OFS_EN_CLR    = 'h180;
  localparam int unsigned OFS_PEND_SET  = 'h200;
  localparam int unsigned OFS_PEND_CLR  = 'h280;
  localparam int unsigned OFS_PRIO_BASE = 'h400;
  // Each priority word packs this many byte-wide fields
  localparam int unsigned FIELDS_PER_WORD = 4;
  localparam int unsigned FIELD_W         = 8;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  parameter int ADDR_W    = 12,
  parameter int ID_W      = 6
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bus_wr,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic [31:0]                          bus_wdata,
  output logic [31:0]                          bus_rdata,
  input  logic [NUM_LINES-1:0]                 irq_in,
  input  logic [NUM_LINES-1:0]                 line_active,
  input  logic                                 take_fire,
  input  logic [ID_W-1:0]                      take_id,
  output logic [NUM_LINES-1:0]                 en_q,
  output logic [NUM_LINES-1:0]                 pend_q,
  output logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio_q
);
  localparam int NUM_PRIO_REGS = (NUM_LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
  localparam int FIELD_LSB     = FIELD_W - PRIO_BITS;

  logic                 hit_en_set, hit_en_clr, hit_pd_set, hit_pd_clr;
  logic [NUM_LINES-1:0] en_set, en_clr, pend_set, pend_clr, take_mask;
  logic [NUM_LINES-1:0] en_d, pend_d;
  logic                 en_upd;

  assign hit_en_set = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET));
  assign hit_en_clr = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR));
  assign hit_pd_set = bus_wr && (bus_addr == ADDR_W'(OFS_PEND_SET));
  assign hit_pd_clr = bus_wr && (bus_addr == ADDR_W'(OFS_PEND_CLR));

  assign en_set   = hit_en_set ? bus_wdata[NUM_LINES-1:0] : '0;
  assign en_clr   = hit_en_clr ? bus_wdata[NUM_LINES-1:0] : '0;
  assign pend_set = hit_pd_set ? bus_wdata[NUM_LINES-1:0] : '0;
  assign pend_clr = hit_pd_clr ? bus_wdata[NUM_LINES-1:0] : '0;

  always_comb begin
    take_mask = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      take_mask[i] = take_fire && (take_id == ID_W'(i));
    end
  end

  // Next state: enable changes only on its two addresses
  assign en_upd = hit_en_set || hit_en_clr;
  assign en_d   = (en_q & ~en_clr) | en_set;

  // Next state: software set wins over a take; a line in service does not re-pend
  assign pend_d = (pend_q & ~pend_clr & ~take_mask) | pend_set
                | (irq_in & ~line_active & ~take_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // One priority field per line, each with its own word-address enable
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
    localparam int unsigned WORD_OFS = OFS_PRIO_BASE + 4 * (g / FIELDS_PER_WORD);
    localparam int          BYTE_LSB = FIELD_W * (g % FIELDS_PER_WORD) + FIELD_LSB;
    logic                 prio_we;
    logic [PRIO_BITS-1:0] prio_d;
    assign prio_we = bus_wr && (bus_addr == ADDR_W'(WORD_OFS));
    assign prio_d  = bus_wdata[BYTE_LSB +: PRIO_BITS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[g] <= '0;
      end else if (prio_we) begin
        prio_q[g] <= prio_d;
      end
    end
  end

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_EN_SET) || bus_addr == ADDR_W'(OFS_EN_CLR)) begin
      bus_rdata[NUM_LINES-1:0] = en_q;
    end else if (bus_addr == ADDR_W'(OFS_PEND_SET) || bus_addr == ADDR_W'(OFS_PEND_CLR)) begin
      bus_rdata[NUM_LINES-1:0] = pend_q;
    end else begin
      for (int r = 0; r < NUM_PRIO_REGS; r++) begin
        if (bus_addr == ADDR_W'(OFS_PRIO_BASE + 4 * r)) begin
          for (int k = 0; k < FIELDS_PER_WORD; k++) begin
            if (FIELDS_PER_WORD * r + k < NUM_LINES) begin
              bus_rdata[FIELD_W * k + FIELD_LSB +: PRIO_BITS] = prio_q[FIELDS_PER_WORD * r + k];
            end
          end
        end
      end
    end
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> ((pend_q & $past(take_mask & ~pend_set)) == '0))
    else $error("taken line still pending"); // R10

  AST_ZERO_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en_set && bus_wdata[NUM_LINES-1:0] == '0) |=> $stable(en_q))
    else $error("zero write changed enables"); // R1
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  parameter int ID_W      = 6,
  parameter int LVL_W     = 3
) (
  input  logic [NUM_LINES-1:0]                 pend,
  input  logic [NUM_LINES-1:0]                 en,
  input  logic [NUM_LINES-1:0][PRIO_BITS-1:0]  prio,
  input  logic                                 mask_all,
  input  logic                                 nmi_pend,
  input  logic [LVL_W-1:0]                     cur_lvl,
  output logic                                 req_valid,
  output logic [ID_W-1:0]                      req_id,
  output logic [LVL_W-1:0]                     req_lvl
);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_LINES);

  logic                 found;
  logic [PRIO_BITS-1:0] best_p;
  logic [ID_W-1:0]      best_idx;

  // Scan from the top so that the lowest index wins a tie
  always_comb begin
    found    = 1'b0;
    best_p   = '1;
    best_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend[i] && en[i] && !mask_all && (!found || prio[i] <= best_p)) begin
        found    = 1'b1;
        best_p   = prio[i];
        best_idx = ID_W'(i);
      end
    end
  end

  // Level 0 belongs to the non-maskable line; programmable value p maps to p+1
  always_comb begin
    if (nmi_pend) begin
      req_id    = NMI_ID;
      req_lvl   = '0;
      req_valid = (cur_lvl != '0);
    end else begin
      req_id    = best_idx;
      req_lvl   = LVL_W'(best_p) + LVL_W'(1);
      req_valid = found && (LVL_W'(best_p) + LVL_W'(1) < cur_lvl);
    end
  end
endmodule

// File: rtl/irqc_active_stack.sv
module irqc_active_stack #(
  parameter int NUM_LINES = 32,
  parameter int ID_W      = 6,
  parameter int LVL_W     = 3,
  parameter int DEPTH     = 5,
  parameter int IDLE_LVL  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [ID_W-1:0]      push_id,
  input  logic [LVL_W-1:0]     push_lvl,
  input  logic                 pop_req,
  output logic [LVL_W-1:0]     cur_lvl,
  output logic [NUM_LINES-1:0] line_active,
  output logic                 nmi_active
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [LVL_W-1:0] lvl_q [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d;
  logic             pop;

  assign pop = pop_req && (sp_q != '0);

  always_comb begin
    sp_d = sp_q;
    if (push) begin
      sp_d = sp_q + SP_W'(1);
    end else if (pop) begin
      sp_d = sp_q - SP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (push || pop) begin
      sp_q <= sp_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic we;
    assign we = push && (sp_q == SP_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[e]  <= '0;
        lvl_q[e] <= '0;
      end else if (we) begin
        id_q[e]  <= push_id;
        lvl_q[e] <= push_lvl;
      end
    end
  end

  always_comb begin
    cur_lvl     = LVL_W'(IDLE_LVL);
    line_active = '0;
    nmi_active  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_q == SP_W'(i + 1)) begin
        cur_lvl = lvl_q[i];
      end
      if (SP_W'(i) < sp_q) begin
        if (id_q[i] == ID_W'(NUM_LINES)) begin
          nmi_active = 1'b1;
        end
        for (int j = 0; j < NUM_LINES; j++) begin
          if (id_q[i] == ID_W'(j)) begin
            line_active[j] = 1'b1;
          end
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sp_q < SP_W'(DEPTH)))
    else $error("active stack overflow"); // R9

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_lvl < cur_lvl))
    else $error("take without strictly higher urgency"); // R9

  AST_POP_UNWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (sp_q == $past(sp_q) - SP_W'(1)))
    else $error("return did not unwind one level"); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int  NUM_LINES = 32,
  parameter int  PRIO_BITS = 2,
  parameter int  ADDR_W    = 12,
  localparam int ID_W      = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 mask_all,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id,
  input  logic                 req_take,
  input  logic                 req_ret
);
  localparam int              NUM_PRIO = 1 << PRIO_BITS;
  localparam int              IDLE_LVL = NUM_PRIO + 1;
  localparam int              LVL_W    = $clog2(IDLE_LVL + 1);
  localparam int              DEPTH    = NUM_PRIO + 1;
  localparam logic [ID_W-1:0] NMI_ID   = ID_W'(NUM_LINES);

  // Asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0]                en_q, pend_q, line_active;
  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio_q;
  logic [LVL_W-1:0]                    cur_lvl, win_lvl;
  logic                                nmi_active, take_fire;
  logic                                nmi_pend_q, nmi_pend_d, nmi_take;

  assign take_fire = req_take && req_valid && !req_ret;
  assign nmi_take  = take_fire && (req_id == NMI_ID);

  assign nmi_pend_d = (nmi_pend_q && !nmi_take) || (nmi_in && !nmi_active && !nmi_take);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_pend_q <= nmi_pend_d;
    end
  end

  irqc_regs #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .ID_W(ID_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .line_active(line_active),
    .take_fire(take_fire), .take_id(req_id),
    .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q)
  );

  irqc_arbiter #(
    .NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W), .LVL_W(LVL_W)
  ) u_arb (
    .pend(pend_q), .en(en_q), .prio(prio_q), .mask_all(mask_all),
    .nmi_pend(nmi_pend_q), .cur_lvl(cur_lvl),
    .req_valid(req_valid), .req_id(req_id), .req_lvl(win_lvl)
  );

  irqc_active_stack #(
    .NUM_LINES(NUM_LINES), .ID_W(ID_W), .LVL_W(LVL_W), .DEPTH(DEPTH), .IDLE_LVL(IDLE_LVL)
  ) u_stack (
    .clk(clk), .rst_n(rst_sync_n),
    .push(take_fire), .push_id(req_id), .push_lvl(win_lvl), .pop_req(req_ret),
    .cur_lvl(cur_lvl), .line_active(line_active), .nmi_active(nmi_active)
  );

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_all && req_valid) |-> (req_id == NMI_ID))
    else $error("masked line requested"); // R7

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nmi_pend_q && !nmi_active) |-> (req_valid && req_id == NMI_ID))
    else $error("non-maskable request not presented"); // R8
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk, rst_n, bus_wr, nmi_in, mask_all, req_take, req_ret;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, irq_in;
  logic        req_valid;
  logic [5:0]  req_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int b_prio [32];

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .nmi_in(nmi_in), .mask_all(mask_all), .req_valid(req_valid),
    .req_id(req_id), .req_take(req_take), .req_ret(req_ret)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One clock of stimulus, everything released at the following falling edge
  task automatic cyc(input logic tk, input logic rt, input logic w,
                     input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_take = tk; req_ret = rt; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    req_take = 0; req_ret = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(0, 0, 1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic take();
    cyc(1, 0, 0, 12'h000, 32'h0);
  endtask

  task automatic ret();
    cyc(0, 1, 0, 12'h000, 32'h0);
  endtask

  task automatic clean();
    irq_in = '0; mask_all = 0;
    wr(12'h180, 32'hFFFF_FFFF);
    wr(12'h280, 32'hFFFF_FFFF);
  endtask

  function automatic int model_win(input logic [31:0] p, input logic [31:0] e);
    int best = -1;
    int bp = 4;
    for (int i = 0; i < 32; i++) begin
      if (p[i] && e[i] && b_prio[i] < bp) begin
        best = i; bp = b_prio[i];
      end
    end
    return best;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, pat, enp, w;
    int exp_w;
    rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
    nmi_in = 0; mask_all = 0; req_take = 0; req_ret = 0;
    for (int i = 0; i < 32; i++) b_prio[i] = (i * 5 + i / 3) % 4;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Reset state
    rd(12'h100, v); chk("R1 reset enable", v, 0);
    rd(12'h200, v); chk("R2 reset pending", v, 0);
    rd(12'h400, v); chk("R3 reset priority", v, 0);
    chk("R5 reset no request", {31'b0, req_valid}, 0);

    // R1 enable set/clear
    wr(12'h100, 32'hA5A5_0F0F); rd(12'h180, v); chk("R1 set then read clear addr", v, 32'hA5A5_0F0F);
    wr(12'h100, 32'h0);         rd(12'h100, v); chk("R1 zero set no effect", v, 32'hA5A5_0F0F);
    wr(12'h180, 32'h0000_FFFF); rd(12'h100, v); chk("R1 clear low half", v, 32'hA5A5_0000);
    wr(12'h180, 32'h0);         rd(12'h100, v); chk("R1 zero clear no effect", v, 32'hA5A5_0000);
    wr(12'h180, 32'hFFFF_FFFF); rd(12'h100, v); chk("R1 clear all", v, 0);

    // R2 pending set/clear
    wr(12'h200, 32'h00C3_1234); rd(12'h280, v); chk("R2 set then read clear addr", v, 32'h00C3_1234);
    wr(12'h280, 32'h0000_0234); rd(12'h200, v); chk("R2 partial clear", v, 32'h00C3_1000);
    wr(12'h200, 32'h0);         rd(12'h200, v); chk("R2 zero set no effect", v, 32'h00C3_1000);
    wr(12'h280, 32'hFFFF_FFFF); rd(12'h200, v); chk("R2 clear all", v, 0);

    // R3 priority storage sweep
    for (int r = 0; r < 8; r++) begin
      w = 32'h3C5A_96E1 ^ (r * 32'h1111_1111);
      wr(12'h400 + 12'(4 * r), w);
      rd(12'h400 + 12'(4 * r), v);
      chk("R3 only top two bits kept", v, w & 32'hC0C0_C0C0);
    end
    for (int r = 0; r < 8; r++) begin
      w = 0;
      for (int k = 0; k < 4; k++) w |= ((32'(b_prio[4 * r + k]) << 6) | 32'h15) << (8 * k);
      wr(12'h400 + 12'(4 * r), w);
    end

    // R5/R6 arbitration sweep
    for (int t = 0; t < 40; t++) begin
      pat = (32'(t + 1) * 32'h9E37_79B1) ^ (32'(t) << 7);
      pat = pat >> (t % 23);
      if (pat == 0) pat = 32'h1;
      enp = (t < 20) ? 32'hFFFF_FFFF : ~((32'(t) * 32'h0F0F_3333) ^ pat);
      wr(12'h280, 32'hFFFF_FFFF);
      wr(12'h200, pat);
      wr(12'h180, 32'hFFFF_FFFF);
      wr(12'h100, enp);
      #1;
      exp_w = model_win(pat, enp);
      chk("R5 request valid", {31'b0, req_valid}, {31'b0, exp_w >= 0});
      if (exp_w >= 0) chk("R5 winner number", {26'b0, req_id}, 32'(exp_w));
      if (t >= 20) begin
        rd(12'h200, v); chk("R6 disabled lines stay pending", v, pat);
      end
    end
    clean();

    // R7 global mask, R8 non-maskable
    wr(12'h200, 32'hFFFF_FFFF); wr(12'h100, 32'hFFFF_FFFF);
    #1 chk("R5 all pending wins line 0", {26'b0, req_id}, 0);
    mask_all = 1;
    #1 chk("R7 mask blocks lines", {31'b0, req_valid}, 0);
    nmi_in = 1; @(negedge clk); #1;
    chk("R7 non-maskable passes mask", {31'b0, req_valid}, 1);
    chk("R8 non-maskable number", {26'b0, req_id}, 32);
    take(); nmi_in = 0;
    mask_all = 0; #1;
    chk("R9 lines wait under non-maskable handler", {31'b0, req_valid}, 0);
    ret(); #1;
    chk("R10 return reopens lines", {31'b0, req_valid}, 1);
    chk("R10 return winner", {26'b0, req_id}, 0);
    clean();
    nmi_in = 1; @(negedge clk); #1;
    chk("R8 not disabled by clear-enable", {26'b0, req_id}, 32);
    take(); nmi_in = 0; ret();

    // R9/R10 nesting
    wr(12'h400, 32'h8000_40C0); wr(12'h404, 32'hC0C0_80C0);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h200, 32'h8); #1 chk("R5 single pending", {26'b0, req_id}, 3);
    take(); #1 chk("R10 taken no request", {31'b0, req_valid}, 0);
    rd(12'h200, v); chk("R10 take clears pending", v, 0);
    wr(12'h200, 32'h20); #1 chk("R9 equal level waits", {31'b0, req_valid}, 0);
    wr(12'h200, 32'h2); #1 chk("R9 more urgent preempts", {26'b0, req_id}, 1);
    take(); #1 chk("R9 nested no request", {31'b0, req_valid}, 0);
    ret(); #1 chk("R10 restores previous level", {31'b0, req_valid}, 0);
    ret(); #1 chk("R10 idle admits waiting line", {26'b0, req_id}, 5);
    take(); ret();

    // R12 take coinciding with return
    wr(12'h200, 32'h8); take();
    wr(12'h200, 32'h2);
    cyc(1, 1, 0, 12'h000, 32'h0);
    rd(12'h200, v); chk("R12 take with return ignored", v, 32'h2);
    chk("R12 request still raised", {26'b0, req_id}, 1);
    take(); ret();
    cyc(1, 0, 0, 12'h000, 32'h0);
    wr(12'h200, 32'h20); #1 chk("R12 stray take ignored", {26'b0, req_id}, 5);
    take(); ret();

    // R13 take coinciding with set-pending of the same line
    wr(12'h200, 32'h4); #1 chk("R5 priority zero line", {26'b0, req_id}, 2);
    cyc(1, 0, 1, 12'h200, 32'h4);
    rd(12'h200, v); chk("R13 pending survives take", v, 32'h4);
    chk("R13 no self preemption", {31'b0, req_valid}, 0);
    nmi_in = 1; @(negedge clk); #1;
    chk("R8 preempts priority zero handler", {26'b0, req_id}, 32);
    take(); nmi_in = 0; ret();
    ret(); #1 chk("R13 re-raised after return", {26'b0, req_id}, 2);
    take(); ret();

    // R4/R11 level lines
    irq_in[7] = 1; @(negedge clk); #1;
    rd(12'h200, v); chk("R4 level sets pending", v, 32'h80);
    wr(12'h280, 32'h80); rd(12'h200, v); chk("R4 clear loses to high line", v, 32'h80);
    take(); rd(12'h200, v); chk("R11 no re-pend in service", v, 0);
    ret(); @(negedge clk); rd(12'h200, v); chk("R11 re-pend after return", v, 32'h80);
    #1 chk("R11 re-request after return", {26'b0, req_id}, 7);
    irq_in[7] = 0; take(); ret();
    wr(12'h280, 32'hFFFF_FFFF); rd(12'h200, v); chk("R4 low line clears", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule